// File: doc/BRIEF.md
# Two-Tier Priority Bus Arbiter with Daisy-Chained Levels

This block decides which of several bus masters may own a shared bus next. Masters are sorted into priority levels, and every level has one request line and one grant line between it and the arbiter. Within a level the masters hang on a grant chain. The arbiter sees only whether anyone on a level wants the bus. When the bus is free it raises the grant of the most urgent requesting level. That grant then travels down the level's chain, and the first requesting master it reaches keeps it.

A master that receives the grant drives the bus-busy line high for as long as it uses the bus, and keeps its request up during that time. The arbiter holds the level grant until busy falls again. It never takes the bus away from an owner, even when a more urgent level starts to request. The one-hot per-master grant vector shows the current owner.

Top module: `multi_level_chain_arbiter`

## Requirements
- R1: While reset is active, and after reset is applied at any time, no level grant and no master grant is high.
- R2: A level counts as requesting when any of its masters requests. Master `d` of level `l` is bit `l*4+d` of `dev_req`, and level `l` is bit `l` of `lvl_grant`.
- R3: A new level grant appears only on the clock edge after a cycle in which no grant was active, busy was low and at least one request was present. If busy is high while no grant is active, no grant is issued.
- R4: When several levels request at the same time, the lowest-numbered level is granted. Level 0 is the most urgent.
- R5: Within the granted level, the grant goes to the requesting master with the lowest position number, meaning the one nearest the arbiter. Masters further down the chain receive nothing.
- R6: A master that is not requesting passes the grant on to the next position. At most one master grant is high, and only inside the granted level.
- R7: Once busy has been seen high during a grant, the level grant stays unchanged for as long as busy stays high. This holds even when a more urgent level requests.
- R8: The clock edge after busy falls from a held grant clears the level grant. A new grant can follow on the edge after that.
- R9: If every master on the granted level withdraws its request before busy is raised, the grant is withdrawn on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| dev_req | input | 16 | Request from each master, level-major order |
| bus_busy | input | 1 | Driven high by the current owner while it uses the bus |
| lvl_grant | output | 4 | One-hot grant line of each level |
| dev_grant | output | 16 | One-hot grant received by each master (current owner) |

## Verification
Two pairs of events can fall in the same cycle. The first pair is the release of the bus and the arrival of a more urgent request. The second is a new request together with a busy line that is high while no grant is active. The stimulus raises a level-0 request during a level-1 hold. It drops busy in a cycle where requests are still pending, and it raises busy from outside while the arbiter is idle. The results are judged on the level and master grant vectors. The hold must not move. The release must give one empty cycle before the urgent level wins. An idle arbiter must not grant while busy is high.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;

  typedef enum logic [1:0] {
    ARB_IDLE  = 2'd0,
    ARB_OFFER = 2'd1,
    ARB_HELD  = 2'd2
  } arb_state_e;

endpackage

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int W = 4
) (
  input  logic [W-1:0] req,
  output logic [W-1:0] pick
);

  // Lowest index wins: scan from the top so the last hit is the lowest.
  always_comb begin
    pick = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) begin
        pick    = '0;
        pick[i] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/link_cell.sv
module link_cell (
  input  logic gin,
  input  logic req,
  output logic take,
  output logic gout
);

  assign take = gin & req;
  assign gout = gin & ~req;

endmodule

// File: rtl/daisy_level.sv
module daisy_level #(
  parameter int DEVS = 4
) (
  input  logic            grant_in,
  input  logic [DEVS-1:0] req,
  output logic [DEVS-1:0] take
);

  logic [DEVS:0] ripple;

  assign ripple[0] = grant_in;

  for (genvar d = 0; d < DEVS; d++) begin : g_cell
    link_cell u_cell (
      .gin  (ripple[d]),
      .req  (req[d]),
      .take (take[d]),
      .gout (ripple[d+1])
    );
  end

endmodule

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import bus_arb_pkg::*;
#(
  parameter int NUM_LVL = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LVL-1:0] lvl_req,
  input  logic [NUM_LVL-1:0] lvl_pick,
  input  logic               bus_busy,
  output logic [NUM_LVL-1:0] lvl_grant
);

  arb_state_e         state_q, state_d;
  logic [NUM_LVL-1:0] lvl_q, lvl_d;
  logic               upd;

  always_comb begin
    state_d = state_q;
    lvl_d   = lvl_q;
    unique case (state_q)
      ARB_IDLE: begin
        if (!bus_busy && (|lvl_req)) begin
          state_d = ARB_OFFER;
          lvl_d   = lvl_pick;
        end
      end
      ARB_OFFER: begin
        if (bus_busy) begin
          state_d = ARB_HELD;
        end else if ((lvl_req & lvl_q) == '0) begin
          state_d = ARB_IDLE;
          lvl_d   = '0;
        end
      end
      ARB_HELD: begin
        if (!bus_busy) begin
          state_d = ARB_IDLE;
          lvl_d   = '0;
        end
      end
      default: begin
        state_d = ARB_IDLE;
        lvl_d   = '0;
      end
    endcase
  end

  assign upd = (state_d != state_q) || (lvl_d != lvl_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ARB_IDLE;
      lvl_q   <= '0;
    end else if (upd) begin
      state_q <= state_d;
      lvl_q   <= lvl_d;
    end
  end

  assign lvl_grant = lvl_q;

endmodule

// File: rtl/multi_level_chain_arbiter.sv
module multi_level_chain_arbiter #(
  parameter int NUM_LVL      = 4,
  parameter int DEVS_PER_LVL = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_LVL*DEVS_PER_LVL-1:0] dev_req,
  input  logic                            bus_busy,
  output logic [NUM_LVL-1:0]              lvl_grant,
  output logic [NUM_LVL*DEVS_PER_LVL-1:0] dev_grant
);

  localparam int NDEV = NUM_LVL * DEVS_PER_LVL;

  logic [1:0]         rst_pipe;
  logic               rst_sync_n;
  logic [NUM_LVL-1:0] lvl_req;
  logic [NUM_LVL-1:0] lvl_pick;
  logic [NDEV-1:0]    take_all;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    assign lvl_req[l] = |dev_req[l*DEVS_PER_LVL +: DEVS_PER_LVL];

    daisy_level #(.DEVS(DEVS_PER_LVL)) u_chain (
      .grant_in (lvl_grant[l]),
      .req      (dev_req[l*DEVS_PER_LVL +: DEVS_PER_LVL]),
      .take     (take_all[l*DEVS_PER_LVL +: DEVS_PER_LVL])
    );
  end

  prio_pick #(.W(NUM_LVL)) u_pick (
    .req  (lvl_req),
    .pick (lvl_pick)
  );

  arb_ctrl #(.NUM_LVL(NUM_LVL)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .lvl_req   (lvl_req),
    .lvl_pick  (lvl_pick),
    .bus_busy  (bus_busy),
    .lvl_grant (lvl_grant)
  );

  assign dev_grant = take_all;

endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int NUM_LVL = 4,
  parameter int DEVS    = 4
) (
  input logic                    clk,
  input logic                    rst_sync_n,
  input logic                    bus_busy,
  input logic [NUM_LVL*DEVS-1:0] dev_req,
  input logic [NUM_LVL-1:0]      lvl_grant,
  input logic [NUM_LVL*DEVS-1:0] dev_grant
);

  always @(negedge clk) begin
    if (!rst_sync_n) begin
      assert_quiet_in_reset_R1: assert (lvl_grant == '0 && dev_grant == '0)
        else $error("grant active during reset");
    end
  end

  assert_no_grant_when_busy_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lvl_grant == '0 && bus_busy) |=> (lvl_grant == '0));

  assert_grant_after_free_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lvl_grant == '0 && !bus_busy && (|dev_req)) |=> $onehot(lvl_grant));

  assert_single_level_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(lvl_grant));

  assert_single_owner_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(dev_grant));

  assert_owner_requests_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((dev_grant & ~dev_req) == '0));

  assert_hold_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lvl_grant != '0 && bus_busy) |=> $stable(lvl_grant));

  assert_release_after_busy_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lvl_grant != '0 && !bus_busy && $past(bus_busy)) |=> (lvl_grant == '0));

endmodule

bind multi_level_chain_arbiter arb_checker #(
  .NUM_LVL (NUM_LVL),
  .DEVS    (DEVS_PER_LVL)
) u_arb_checker (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .bus_busy   (bus_busy),
  .dev_req    (dev_req),
  .lvl_grant  (lvl_grant),
  .dev_grant  (dev_grant)
);

// File: tb/test_multi_level_chain_arbiter.sv
module test_multi_level_chain_arbiter;

  logic        clk;
  logic        rst_n;
  logic [15:0] dev_req;
  logic        bus_busy;
  logic [3:0]  lvl_grant;
  logic [15:0] dev_grant;

  int n_tests;
  int n_fail;
  bit done;

  multi_level_chain_arbiter i_multi_level_chain_arbiter (
    .clk       (clk),
    .rst_n     (rst_n),
    .dev_req   (dev_req),
    .bus_busy  (bus_busy),
    .lvl_grant (lvl_grant),
    .dev_grant (dev_grant)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {requests, busy, expected level grant, expected master grant}
  localparam int NV = 21;
  localparam logic [36:0] VEC [NV] = '{
    {16'h0000, 1'b0, 4'b0000, 16'h0000}, // idle, nothing pending (R3)
    {16'h0030, 1'b0, 4'b0010, 16'h0010}, // level 1 granted, nearest master (R2, R5)
    {16'h0030, 1'b1, 4'b0010, 16'h0010}, // owner raises busy
    {16'h0031, 1'b1, 4'b0010, 16'h0010}, // urgent level 0 arrives, no preemption (R7)
    {16'h0031, 1'b0, 4'b0000, 16'h0000}, // busy falls, grant cleared (R8)
    {16'h0031, 1'b0, 4'b0001, 16'h0001}, // level 0 beats level 1 (R4)
    {16'h0030, 1'b0, 4'b0000, 16'h0000}, // level 0 withdrew before busy (R9)
    {16'h0030, 1'b1, 4'b0000, 16'h0000}, // idle but busy high: no grant (R3)
    {16'h0030, 1'b0, 4'b0010, 16'h0010}, // busy low again, level 1 granted
    {16'h0020, 1'b0, 4'b0010, 16'h0020}, // first master drops, grant passes on (R6)
    {16'h0020, 1'b1, 4'b0010, 16'h0020},
    {16'h0020, 1'b0, 4'b0000, 16'h0000}, // release (R8)
    {16'hC000, 1'b0, 4'b1000, 16'h4000}, // level 3, position 2 wins over 3 (R5)
    {16'hC000, 1'b1, 4'b1000, 16'h4000},
    {16'h8000, 1'b0, 4'b0000, 16'h0000},
    {16'h8000, 1'b0, 4'b1000, 16'h8000}, // far end of chain (R6)
    {16'h8000, 1'b1, 4'b1000, 16'h8000},
    {16'h0000, 1'b0, 4'b0000, 16'h0000},
    {16'h0F00, 1'b0, 4'b0100, 16'h0100}, // whole level 2 requests (R5)
    {16'h0F00, 1'b1, 4'b0100, 16'h0100},
    {16'h0F00, 1'b0, 4'b0000, 16'h0000}
  };

  task automatic check16(input string what, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    n_tests  = 0;
    n_fail   = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    dev_req  = '0;
    bus_busy = 1'b0;
    repeat (3) @(negedge clk);
    check16("R1 level grant in reset", {12'h0, lvl_grant}, 16'h0);
    check16("R1 master grant in reset", dev_grant, 16'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      dev_req  = VEC[i][36:21];
      bus_busy = VEC[i][20];
      @(negedge clk);
      check16($sformatf("vector %0d level grant R2/R3/R4/R7/R8/R9", i),
              {12'h0, lvl_grant}, {12'h0, VEC[i][19:16]});
      check16($sformatf("vector %0d master grant R5/R6", i),
              dev_grant, VEC[i][15:0]);
    end

    // R5: every master requests, level 0 position 0 wins
    dev_req  = 16'hFFFF;
    bus_busy = 1'b0;
    @(negedge clk);
    check16("R5 all request, master grant", dev_grant, 16'h0001);
    check16("R4 all request, level grant", {12'h0, lvl_grant}, 16'h0001);

    // R8: release with a pending request leaves exactly one empty cycle
    bus_busy = 1'b1;
    @(negedge clk);
    dev_req  = 16'h0004;
    @(negedge clk);
    check16("R7 held after own drop of neighbours", {12'h0, lvl_grant}, 16'h0001);
    check16("R6 grant passes to position 2", dev_grant, 16'h0004);
    bus_busy = 1'b0;
    @(negedge clk);
    check16("R8 empty cycle after release", {12'h0, lvl_grant}, 16'h0000);
    @(negedge clk);
    check16("R8 regrant after empty cycle", dev_grant, 16'h0004);

    // R1: reset applied while a grant is held
    bus_busy = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check16("R1 level grant cleared by reset", {12'h0, lvl_grant}, 16'h0);
    check16("R1 master grant cleared by reset", dev_grant, 16'h0);
    dev_req  = '0;
    bus_busy = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check16("R1 quiet after reset release", {12'h0, lvl_grant}, 16'h0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule